// File: doc/BRIEF.md
# Pipelined Odd-Even Transposition Sorter

This block sorts a fixed-size group of unsigned values into ascending order using a network of compare-and-swap cells. The cells are arranged in clocked stages, and every cell in a stage works at the same time. The caller presents the whole group as one flat vector and pulses `start` for one cycle. Exactly `N` clocks later the block raises `done` for one cycle and presents the sorted group on `out_vec`. The smallest value is in lane 0 and the largest is in lane `N-1`.

Every stage has its own registers, so the network is a true pipeline. A new group may be started on every clock, and each group comes out `N` clocks after its own start, in the order the groups went in. The block has no back-pressure. The caller must take each result in the cycle that `done` is high. After that, `out_vec` keeps showing the most recent result until the next result replaces it. `start` and `done` are plain strobes and no valid/ready handshake is needed, because the block can always accept a group and always produces its results on a fixed schedule.

The network has `N` stages and they alternate in kind. A stage of the first kind compares the lane pairs (0,1), (2,3), and so on. A stage of the second kind compares (1,2), (3,4), and so on. Any lane without a partner in a stage is simply registered. A cell swaps its two lanes only when the lower lane holds the strictly greater value, so equal values are never exchanged. There are N(N-1)/2 compare-and-swap cells in all, which is 120 for the default N = 16.

Top module: `tsn_sorter`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and every lane of `out_vec` is 0.
- R2: `done` is high for exactly one cycle, `N` rising clock edges after the edge at which `start` was sampled high. It is never high at any other time.
- R3: When `done` is high, the lanes of `out_vec` are in non-decreasing order. Lane i occupies bits [i*W +: W], so lane 0 holds the smallest value and lane N-1 holds the largest.
- R4: When `done` is high, `out_vec` holds exactly the same multiset of values as the `in_vec` that was sampled with the matching `start`.
- R5: Repeated values are kept, including a group in which every lane holds the same value. The count of each value in the output equals its count in the input.
- R6: In every cycle where `done` is low, `out_vec` is unchanged from the previous cycle. It keeps the last result, or zero if there has been no result since reset.
- R7: `start` may be high on consecutive cycles. Every sampled start produces its own `done` pulse and its own result, and the results come out in the order the starts were given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle strobe; `in_vec` is captured at this edge |
| in_vec | input | N*W | Unsorted group; lane i at bits [i*W +: W] |
| done | output | 1 | One-cycle pulse marking a fresh sorted result |
| out_vec | output | N*W | Sorted group, ascending from lane 0 |

## Verification
The sorter is driven with several kinds of input group:
- Pseudo-random groups. These show whether the compare-and-swap cells and the stage pairing are correct in general.
- Groups that are already in ascending order, and groups in strictly descending order. Descending order is the worst case: a value must travel the full width of the network, so it shows whether `N` stages are truly enough.
- Groups where every lane is equal, and groups with heavy repetition mixed with the values 0 and all-ones. These show whether the cells keep duplicates and handle the comparison correctly at the ends of the value range.
- Back-to-back bursts of starts, followed by long idle periods. The bursts show that the stages in the pipeline do not disturb each other. The idle periods show that a result is held rather than overwritten while no new result is due.

// File: rtl/tsn_pkg.sv
package tsn_pkg;

  typedef enum logic {
    PAIR_FROM_ZERO = 1'b0,
    PAIR_FROM_ONE  = 1'b1
  } stage_kind_e;

  function automatic int cas_cells_total(input int n);
    return n * (n - 1) / 2;
  endfunction

  function automatic stage_kind_e kind_of_stage(input int k);
    return (k % 2 == 0) ? PAIR_FROM_ZERO : PAIR_FROM_ONE;
  endfunction

endpackage

// File: rtl/tsn_cas_cell.sv
module tsn_cas_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] lo_q,
  output logic [W-1:0] hi_q
);

  logic swap;

  // swap only when strictly greater, so ties keep their lanes
  assign swap = (a_in > b_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (en) begin
      lo_q <= swap ? b_in : a_in;
      hi_q <= swap ? a_in : b_in;
    end
  end

endmodule

// File: rtl/tsn_pass_cell.sv
module tsn_pass_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
    end else if (en) begin
      d_q <= d_in;
    end
  end

endmodule

// File: rtl/tsn_stage.sv
module tsn_stage #(
  parameter int                  N    = 16,
  parameter int                  W    = 16,
  parameter tsn_pkg::stage_kind_e KIND = tsn_pkg::PAIR_FROM_ZERO
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [N*W-1:0] d_in,
  output logic [N*W-1:0] d_q
);

  localparam int FIRST = (KIND == tsn_pkg::PAIR_FROM_ONE) ? 1 : 0;

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam int REL   = i - FIRST;
    localparam bit IS_LO = (i >= FIRST) && (REL % 2 == 0) && (i + 1 < N);
    localparam bit IS_HI = (i >= FIRST + 1) && (REL % 2 == 1);

    if (IS_LO) begin : g_cas
      tsn_cas_cell #(.W(W)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .a_in  (d_in[i*W +: W]),
        .b_in  (d_in[(i+1)*W +: W]),
        .lo_q  (d_q[i*W +: W]),
        .hi_q  (d_q[(i+1)*W +: W])
      );
    end else if (!IS_HI) begin : g_pass
      tsn_pass_cell #(.W(W)) u_pass (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d_in  (d_in[i*W +: W]),
        .d_q   (d_q[i*W +: W])
      );
    end
  end

endmodule

// File: rtl/tsn_sorter.sv
module tsn_sorter #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] in_vec,
  output logic           done,
  output logic [N*W-1:0] out_vec
);

  localparam int VEC_W  = N * W;
  localparam int STAGES = N;

  logic [VEC_W-1:0] lane_vec [STAGES+1];
  logic             lane_vld [STAGES+1];

  // input capture: one register stage ahead of the network
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_vec[0] <= '0;
      lane_vld[0] <= 1'b0;
    end else begin
      lane_vld[0] <= start;
      if (start) begin
        lane_vec[0] <= in_vec;
      end
    end
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    tsn_stage #(
      .N    (N),
      .W    (W),
      .KIND (tsn_pkg::kind_of_stage(k))
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (lane_vld[k]),
      .d_in  (lane_vec[k]),
      .d_q   (lane_vec[k+1])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_vld[k+1] <= 1'b0;
      end else begin
        lane_vld[k+1] <= lane_vld[k];
      end
    end
  end

  assign done    = lane_vld[STAGES];
  assign out_vec = lane_vec[STAGES];

endmodule

// File: rtl/tsn_sorter_chk.sv
module tsn_sorter_chk #(
  parameter int N = 16,
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N*W-1:0] in_vec,
  input logic           done,
  input logic [N*W-1:0] out_vec
);

  localparam int SUM_W = W + $clog2(N) + 1;

  logic [N-1:0]     start_hist;
  logic [SUM_W-1:0] sum_hist [N];
  logic [SUM_W-1:0] in_sum;
  logic [SUM_W-1:0] out_sum;
  logic             ordered;

  always_comb begin
    in_sum  = '0;
    out_sum = '0;
    ordered = 1'b1;
    for (int i = 0; i < N; i++) begin
      in_sum  = in_sum  + SUM_W'(in_vec[i*W +: W]);
      out_sum = out_sum + SUM_W'(out_vec[i*W +: W]);
    end
    for (int i = 0; i + 1 < N; i++) begin
      if (out_vec[i*W +: W] > out_vec[(i+1)*W +: W]) ordered = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_hist <= '0;
      for (int i = 0; i < N; i++) sum_hist[i] <= '0;
    end else begin
      start_hist  <= {start_hist[N-2:0], start};
      sum_hist[0] <= in_sum;
      for (int i = 1; i < N; i++) sum_hist[i] <= sum_hist[i-1];
    end
  end

  // R2
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_hist[N-1] |=> done);

  // R2
  no_false_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_hist[N-1] |=> !done);

  // R3
  ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ordered);

  // R4
  sum_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_hist[N-1] |=> (out_sum == $past(sum_hist[N-1])));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(out_vec));

endmodule

bind tsn_sorter tsn_sorter_chk #(.N(N), .W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .in_vec  (in_vec),
  .done    (done),
  .out_vec (out_vec)
);

// File: tb/tb_tsn_sorter.sv
`timescale 1ns/1ps
module tb_tsn_sorter;

  localparam int N = 16;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] in_vec = '0;
  logic           done;
  logic [N*W-1:0] out_vec;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  int starts_seen = 0;
  int dones_seen = 0;
  bit finished = 1'b0;
  string cur_tag = "R3 R4";
  int unsigned seed = 32'h1234_5678;

  logic [N*W-1:0] exp_q [$];
  int             due_q [$];
  string          tag_q [$];
  logic [N*W-1:0] hold_v = '0;

  always #5 clk = ~clk;

  tsn_sorter #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec),
    .done(done), .out_vec(out_vec)
  );

  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
    int a [N];
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) a[i] = int'(v[i*W +: W]);
    for (int i = 1; i < N; i++) begin
      int key = a[i];
      int j = i - 1;
      while (j >= 0 && a[j] > key) begin
        a[j+1] = a[j];
        j--;
      end
      a[j+1] = key;
    end
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(a[i]);
    return r;
  endfunction

  function automatic logic [W-1:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[W-1:0];
  endfunction

  // reference model: records each sampled start with its due edge
  always @(posedge clk) begin
    edge_cnt++;
    if (rst_n && start) begin
      exp_q.push_back(ref_sort(in_vec));
      due_q.push_back(edge_cnt + N);
      tag_q.push_back(cur_tag);
      starts_seen++;
    end
  end

  // comparison on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        checks++;
        if (done !== 1'b0 || out_vec !== '0) begin
          errors++;
          $display("FAIL R1 reset: done=%b out=%h expected done=0 out=0", done, out_vec);
        end
      end else begin
        bit exp_done;
        string tg;
        tg = "R6";
        exp_done = (due_q.size() > 0) && (due_q[0] == edge_cnt);
        if (exp_done) begin
          hold_v = exp_q.pop_front();
          void'(due_q.pop_front());
          tg = tag_q.pop_front();
        end
        if (done === 1'b1) dones_seen++;
        checks++;
        if (done !== exp_done) begin
          errors++;
          $display("FAIL R2 edge %0d: done=%b expected %b", edge_cnt, done, exp_done);
        end
        checks++;
        if (out_vec !== hold_v) begin
          errors++;
          $display("FAIL %s edge %0d: out=%h expected %h", tg, edge_cnt, out_vec, hold_v);
        end
      end
    end
  end

  task automatic send(input logic [N*W-1:0] v, input string tg);
    @(negedge clk);
    start   = 1'b1;
    in_vec  = v;
    cur_tag = tg;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      start  = 1'b0;
      in_vec = '0;
    end
  endtask

  function automatic logic [N*W-1:0] rnd_vec();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = rnd();
    return v;
  endfunction

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [N*W-1:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R3 R4: random groups with gaps
    for (int t = 0; t < 3; t++) begin
      send(rnd_vec(), "R3 R4");
      idle(N + 3);
    end

    // R3: already ascending, then strictly descending (worst case)
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 100 + 7);
    send(v, "R3");
    idle(2);
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(16'hFFFF - i * 3);
    send(v, "R3");
    idle(N + 2);

    // R5: every lane equal, then heavy repetition with range extremes
    for (int i = 0; i < N; i++) v[i*W +: W] = 16'h5A5A;
    send(v, "R5");
    idle(N + 1);
    for (int i = 0; i < N; i++)
      v[i*W +: W] = (i % 3 == 0) ? 16'hFFFF : ((i % 3 == 1) ? 16'h0000 : 16'h0042);
    send(v, "R5");
    idle(N + 1);

    // R7: back-to-back burst of starts
    for (int t = 0; t < 6; t++) send(rnd_vec(), "R7");
    idle(1);

    // R6: long idle, result must hold
    idle(2 * N + 4);

    // R7: burst with one-cycle gaps
    for (int t = 0; t < 4; t++) begin
      send(rnd_vec(), "R7");
      idle(1);
    end
    idle(N + 6);

    checks++;
    if (starts_seen != dones_seen || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 count: dones=%0d expected %0d", dones_seen, starts_seen);
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

endmodule